// File: doc/BRIEF.md
# Two-Pass 4x4 Integer Transform Core

This block computes one of the four small two-dimensional integer transforms used by a video residual coder: the forward core transform, the inverse core transform and the forward and inverse Hadamard transforms. A whole 4x4 block of signed coefficients is presented in parallel on one beat. The block passes twice through one shared set of four butterfly processing elements. The first pass works on the rows and the second pass works on the columns. A register holds the row results between the two passes, and the transposition between the passes is plain wiring.

The input side uses a valid/ready handshake. A block is taken on any cycle in which `in_valid` and `in_ready` are both high. `in_ready` drops for the one cycle of the second pass, so the core accepts at most one block every two cycles. A source that keeps `in_valid` high during that cycle is simply not accepted, and it may present the same block again on the next cycle. The output side has no back-pressure. `out_valid` pulses for one cycle, and `out_data` holds its value until the next block completes.

A raw-scale select applies to the forward core transform only. When it is set, the final wired diagonal shift is skipped, and the core returns the coefficients at a fixed 4x scale with the row and column weights left unequalised. This is the form another stage needs when it reuses the core as one quadrant of a larger forward transform.

Top module: `mtx4_core`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and every output coefficient is 0.
- R2: A block is accepted when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is 0 in the next cycle. `out_valid` is 1 in the cycle after that and lasts exactly one cycle.
- R3: Type code 2'b00 with `in_raw` = 0 gives Z = C·X·Cᵀ, with C rows [1 1 1 1], [2 1 -1 -2], [1 -1 -1 1], [1 -2 2 -1]. Coefficient k = 4·row + col sits at `in_data[k*16 +: 16]` and `out_data[k*23 +: 23]`.
- R4: Type 2'b00 with `in_raw` = 1 returns Z[i][j]·2^(2 - (i mod 2) - (j mod 2)) for each coefficient.
- R5: Type 2'b01 gives the inverse core transform. Each row is transformed first and each column after, and both passes use e0=a0+a2, e1=a0-a2, e2=(a1>>>1)-a3, e3=a1+(a3>>>1), y=[e0+e3, e1+e2, e1-e2, e0-e3].
- R6: Type codes 2'b10 and 2'b11 both give H·X·Hᵀ, with H rows [1 1 1 1], [1 1 -1 -1], [1 -1 -1 1], [1 -1 1 -1].
- R7: A block presented while `in_ready` is 0 is not accepted. It produces no extra `out_valid` pulse and does not change the result of the block in flight.
- R8: Between completions, `out_data` keeps the last completed result unchanged.
- R9: Full-scale 16-bit inputs (all +32767, all -32768, or alternating signs) give exact results for every type, with no wrap-around.
- R10: With `in_valid` held high, blocks are accepted every second cycle, and each result appears two cycles after its own acceptance.
- R11: `in_raw` has no effect on types 2'b01, 2'b10 and 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input block present |
| in_ready | output | 1 | Core can take a block this cycle |
| in_type | input | 2 | 00 forward core, 01 inverse core, 10/11 Hadamard |
| in_raw | input | 1 | Skip forward output scaling |
| in_data | input | 256 | 16 signed 16-bit coefficients, k = 4·row + col |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 368 | 16 signed 23-bit results, k = 4·row + col |

## Verification
The assertions assume only that reset is applied once at the start and that `in_type`, `in_raw` and `in_data` are sampled solely in the acceptance cycle. Apart from that, they hold for any input sequence, including a valid held high during the second pass. The stimulus drives inputs on falling edges and keeps valid data stable until acceptance. It also deliberately changes data while `in_ready` is low, to show that such a block is ignored. The random blocks use a fixed seed across all types. The directed blocks cover impulses and full-scale magnitudes of both signs, so the widest internal sums are reached.

// File: rtl/mtx4_pkg.sv
package mtx4_pkg;

  typedef enum logic [1:0] {
    XF_FWD  = 2'b00,
    XF_INV  = 2'b01,
    XF_HADF = 2'b10,
    XF_HADI = 2'b11
  } xform_e;

  typedef enum logic [1:0] {
    BF_FWD = 2'b00,
    BF_INV = 2'b01,
    BF_HAD = 2'b10
  } bfly_e;

  // Hadamard in either direction uses the same butterfly on both passes.
  function automatic bfly_e bfly_of(input xform_e t);
    case (t)
      XF_FWD:  return BF_FWD;
      XF_INV:  return BF_INV;
      default: return BF_HAD;
    endcase
  endfunction

endpackage

// File: rtl/mtx4_pe.sv
module mtx4_pe
  import mtx4_pkg::*;
#(
  parameter int IW = 20,
  parameter int OW = 23
) (
  input  bfly_e                 kind,
  input  logic signed [IW-1:0]  x [4],
  output logic signed [OW-1:0]  y [4]
);

  logic signed [OW-1:0] a [4];
  logic signed [OW-1:0] e0, e1, e2, e3;

  for (genvar i = 0; i < 4; i++) begin : g_ext
    assign a[i] = {{(OW-IW){x[i][IW-1]}}, x[i]};
  end

  // First butterfly stage.
  always_comb begin
    e0 = '0; e1 = '0; e2 = '0; e3 = '0;
    case (kind)
      BF_FWD: begin
        e0 = a[0] + a[3];
        e1 = a[1] + a[2];
        e2 = a[0] - a[3];
        e3 = a[1] - a[2];
      end
      BF_INV: begin
        e0 = a[0] + a[2];
        e1 = a[0] - a[2];
        e2 = (a[1] >>> 1) - a[3];
        e3 = a[1] + (a[3] >>> 1);
      end
      default: begin
        e0 = a[0] + a[1];
        e1 = a[0] - a[1];
        e2 = a[2] + a[3];
        e3 = a[2] - a[3];
      end
    endcase
  end

  // Second butterfly stage. The forward variant carries an extra factor 2 on
  // the even outputs so that the odd rows stay integer.
  always_comb begin
    y[0] = '0; y[1] = '0; y[2] = '0; y[3] = '0;
    case (kind)
      BF_FWD: begin
        y[0] = (e0 + e1) <<< 1;
        y[1] = (e2 <<< 1) + e3;
        y[2] = (e0 - e1) <<< 1;
        y[3] = e2 - (e3 <<< 1);
      end
      BF_INV: begin
        y[0] = e0 + e3;
        y[1] = e1 + e2;
        y[2] = e1 - e2;
        y[3] = e0 - e3;
      end
      default: begin
        y[0] = e0 + e2;
        y[1] = e0 - e2;
        y[2] = e1 - e3;
        y[3] = e1 + e3;
      end
    endcase
  end

endmodule

// File: rtl/mtx4_seq.sv
module mtx4_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  output logic accept,
  output logic busy,
  output logic out_valid
);

  logic busy_q, ov_q;

  assign in_ready  = ~busy_q;
  assign accept    = in_valid & ~busy_q;
  assign busy      = busy_q;
  assign out_valid = ov_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ov_q   <= 1'b0;
    end else begin
      busy_q <= accept;
      ov_q   <= busy_q;
    end
  end

  // R2: an accepted block occupies the second pass on the next cycle
  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy);

  // R2: the second pass is followed by the result strobe
  p_busy_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (out_valid && in_ready));

  // R7: a request during the second pass never starts another pass
  p_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && busy) |=> !busy);

endmodule

// File: rtl/mtx4_oscale.sv
module mtx4_oscale
  import mtx4_pkg::*;
#(
  parameter int W = 23
) (
  input  xform_e               typ,
  input  logic                 raw,
  input  logic signed [W-1:0]  acc [16],
  output logic signed [W-1:0]  res [16]
);

  logic eq_en;
  assign eq_en = (typ == XF_FWD) && !raw;

  // Wired diagonal equalisation: the shift depends only on the coefficient's
  // row and column parity.
  for (genvar k = 0; k < 16; k++) begin : g_sc
    localparam int RO = (k / 4) % 2;
    localparam int CO = k % 2;
    localparam int SH = 2 - RO - CO;
    assign res[k] = eq_en ? (acc[k] >>> SH) : acc[k];
  end

endmodule

// File: rtl/mtx4_core.sv
module mtx4_core
  import mtx4_pkg::*;
#(
  parameter int IN_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [1:0]           in_type,
  input  logic                 in_raw,
  input  logic [16*IN_W-1:0]   in_data,
  output logic                 out_valid,
  output logic [16*(IN_W+7)-1:0] out_data
);

  localparam int MID_W = IN_W + 4;   // row pass gain at most 8
  localparam int ACC_W = IN_W + 7;   // two passes, gain at most 64
  localparam int NC    = 16;

  logic   accept, busy;
  xform_e typ_q;
  logic   raw_q;
  xform_e cur_typ;
  bfly_e  cur_kind;

  logic signed [MID_W-1:0] mid_q  [NC];
  logic signed [ACC_W-1:0] out_q  [NC];
  logic signed [ACC_W-1:0] acc_d  [NC];
  logic signed [ACC_W-1:0] res_d  [NC];
  logic signed [MID_W-1:0] pe_x   [4][4];
  logic signed [ACC_W-1:0] pe_y   [4][4];

  mtx4_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .accept    (accept),
    .busy      (busy),
    .out_valid (out_valid)
  );

  assign cur_typ  = busy ? typ_q : xform_e'(in_type);
  assign cur_kind = bfly_of(cur_typ);

  // PE p handles row p on the first pass and column p on the second pass.
  for (genvar p = 0; p < 4; p++) begin : g_pe
    for (genvar e = 0; e < 4; e++) begin : g_sel
      logic signed [IN_W-1:0] xin;
      assign xin         = in_data[(4*p+e)*IN_W +: IN_W];
      assign pe_x[p][e]  = busy ? mid_q[4*e+p]
                                : {{(MID_W-IN_W){xin[IN_W-1]}}, xin};
      assign acc_d[4*e+p] = pe_y[p][e];
    end
    mtx4_pe #(.IW(MID_W), .OW(ACC_W)) u_pe (
      .kind (cur_kind),
      .x    (pe_x[p]),
      .y    (pe_y[p])
    );
  end

  mtx4_oscale #(.W(ACC_W)) u_osc (
    .typ (typ_q),
    .raw (raw_q),
    .acc (acc_d),
    .res (res_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      typ_q <= XF_FWD;
      raw_q <= 1'b0;
      for (int k = 0; k < NC; k++) begin
        mid_q[k] <= '0;
        out_q[k] <= '0;
      end
    end else if (accept) begin
      typ_q <= xform_e'(in_type);
      raw_q <= in_raw;
      for (int p = 0; p < 4; p++)
        for (int e = 0; e < 4; e++)
          mid_q[4*p+e] <= pe_y[p][e][MID_W-1:0];
    end else if (busy) begin
      for (int k = 0; k < NC; k++)
        out_q[k] <= res_d[k];
    end
  end

  for (genvar k = 0; k < NC; k++) begin : g_out
    assign out_data[k*ACC_W +: ACC_W] = out_q[k];
  end

  // R8: outside the second pass the published result cannot move
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(out_data));

  // R10: a result strobe always lands in a slot where a new block may enter
  p_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);

endmodule

// File: tb/mtx4_core_bench.sv
`timescale 1ns/1ps
module mtx4_core_bench;

  localparam int IW = 16;
  localparam int OW = 23;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [1:0]        in_type = 2'b00;
  logic              in_raw = 1'b0;
  logic [16*IW-1:0]  in_data = '0;
  logic              out_valid;
  logic [16*OW-1:0]  out_data;

  int n_run = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mtx4_core u_mtx4_core (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_type(in_type), .in_raw(in_raw), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  // ---------------- reference model ----------------
  function automatic int cf(input int i, input int k);
    int m [4][4] = '{'{1,1,1,1}, '{2,1,-1,-2}, '{1,-1,-1,1}, '{1,-2,2,-1}};
    return m[i][k];
  endfunction

  function automatic int hm(input int i, input int k);
    int m [4][4] = '{'{1,1,1,1}, '{1,1,-1,-1}, '{1,-1,-1,1}, '{1,-1,1,-1}};
    return m[i][k];
  endfunction

  function automatic void inv1d(input int a[4], output int y[4]);
    int e0, e1, e2, e3;
    e0 = a[0] + a[2];
    e1 = a[0] - a[2];
    e2 = (a[1] >>> 1) - a[3];
    e3 = a[1] + (a[3] >>> 1);
    y[0] = e0 + e3; y[1] = e1 + e2; y[2] = e1 - e2; y[3] = e0 - e3;
  endfunction

  function automatic void ref_blk(input int x[16], input int ty, input bit raw,
                                  output int z[16]);
    int t[16];
    int v[4];
    int w[4];
    if (ty == 1) begin
      for (int r = 0; r < 4; r++) begin
        for (int c = 0; c < 4; c++) v[c] = x[4*r+c];
        inv1d(v, w);
        for (int c = 0; c < 4; c++) t[4*r+c] = w[c];
      end
      for (int c = 0; c < 4; c++) begin
        for (int r = 0; r < 4; r++) v[r] = t[4*r+c];
        inv1d(v, w);
        for (int r = 0; r < 4; r++) z[4*r+c] = w[r];
      end
    end else begin
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++) begin
          int s = 0;
          for (int k = 0; k < 4; k++)
            s += ((ty == 0) ? cf(i,k) : hm(i,k)) * x[4*k+j];
          t[4*i+j] = s;
        end
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++) begin
          int s = 0;
          for (int k = 0; k < 4; k++)
            s += t[4*i+k] * ((ty == 0) ? cf(j,k) : hm(j,k));
          if (ty == 0 && raw) s = s * (4 >> ((i % 2) + (j % 2)));
          z[4*i+j] = s;
        end
    end
  endfunction

  // ---------------- helpers ----------------
  task automatic chk_bit(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic chk_blk(input string req, input int exp[16]);
    int bad_k = -1;
    logic signed [OW-1:0] g;
    n_run++;
    for (int k = 0; k < 16; k++) begin
      g = out_data[k*OW +: OW];
      if (bad_k < 0 && int'(g) != exp[k]) bad_k = k;
    end
    if (bad_k >= 0) begin
      n_bad++;
      g = out_data[bad_k*OW +: OW];
      $display("FAIL %s: coef %0d got %0d expected %0d", req, bad_k, int'(g), exp[bad_k]);
    end
  endtask

  task automatic drive(input int x[16], input int ty, input bit raw);
    for (int k = 0; k < 16; k++) in_data[k*IW +: IW] = 16'(x[k]);
    in_type = 2'(ty);
    in_raw  = raw;
    in_valid = 1'b1;
  endtask

  task automatic run_one(input string req, input int x[16], input int ty, input bit raw);
    int z[16];
    ref_blk(x, ty, raw, z);
    @(negedge clk);
    drive(x, ty, raw);
    chk_bit({req, " ready"}, in_ready, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    chk_bit("R2 no early valid", out_valid, 1'b0);
    @(negedge clk);
    chk_bit("R2 valid", out_valid, 1'b1);
    chk_blk(req, z);
    @(negedge clk);
    chk_bit("R2 single pulse", out_valid, 1'b0);
  endtask

  function automatic void rnd_blk(output int x[16]);
    for (int k = 0; k < 16; k++) begin
      logic signed [15:0] rv;
      rv = 16'($urandom());
      x[k] = rv;
    end
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  // ---------------- main ----------------
  initial begin
    int x[16];
    int y[16];
    int z[16];
    int zs[6][16];
    int dummy;
    dummy = $urandom(32'd20240611);

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_bit("R1 out_valid", out_valid, 1'b0);
    chk_bit("R1 in_ready", in_ready, 1'b1);
    for (int k = 0; k < 16; k++) z[k] = 0;
    chk_blk("R1 out_data", z);

    // R3 forward: impulse then random
    for (int k = 0; k < 16; k++) x[k] = 0;
    x[0] = 1;
    run_one("R3 impulse", x, 0, 1'b0);
    x[0] = 0; x[5] = -7;
    run_one("R3 impulse2", x, 0, 1'b0);
    for (int n = 0; n < 8; n++) begin
      rnd_blk(x);
      run_one("R3 random", x, 0, 1'b0);
    end
    // R4 raw forward
    for (int n = 0; n < 4; n++) begin
      rnd_blk(x);
      run_one("R4 raw", x, 0, 1'b1);
    end
    // R5 inverse (odd values exercise the half-weight truncation)
    for (int n = 0; n < 8; n++) begin
      rnd_blk(x);
      run_one("R5 inverse", x, 1, 1'b0);
    end
    // R6 both Hadamard codes give one result
    for (int n = 0; n < 4; n++) begin
      rnd_blk(x);
      run_one("R6 hadamard 10", x, 2, 1'b0);
      run_one("R6 hadamard 11", x, 3, 1'b0);
    end
    // R11 raw select ignored outside forward
    for (int ty = 1; ty < 4; ty++) begin
      rnd_blk(x);
      run_one("R11 raw ignored", x, ty, 1'b1);
    end
    // R9 full scale
    for (int ty = 0; ty < 4; ty++) begin
      for (int k = 0; k < 16; k++) x[k] = 32767;
      run_one("R9 max", x, ty, 1'b0);
      for (int k = 0; k < 16; k++) x[k] = -32768;
      run_one("R9 min", x, ty, 1'b0);
      for (int k = 0; k < 16; k++) x[k] = (((k / 4) + k) % 2) ? -32768 : 32767;
      run_one("R9 alternating", x, ty, 1'b0);
      if (ty == 0) run_one("R9 alternating raw", x, ty, 1'b1);
    end

    // R7 + R8: change data during the second pass, then watch the hold
    rnd_blk(x);
    rnd_blk(y);
    ref_blk(x, 1, 1'b0, z);
    @(negedge clk);
    drive(x, 1, 1'b0);
    @(negedge clk);
    drive(y, 2, 1'b1);
    chk_bit("R7 not ready", in_ready, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    chk_bit("R7 valid", out_valid, 1'b1);
    chk_blk("R7 first block kept", z);
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      chk_bit("R7 no extra strobe", out_valid, 1'b0);
      chk_blk("R8 hold", z);
    end

    // R10 back-to-back stream with valid held high
    for (int b = 0; b < 6; b++) begin
      @(negedge clk);
      if (b > 0) begin
        chk_bit("R10 stream valid", out_valid, 1'b1);
        chk_blk("R10 stream data", zs[b-1]);
      end
      rnd_blk(x);
      ref_blk(x, b % 4, 1'b0, zs[b]);
      drive(x, b % 4, 1'b0);
      chk_bit("R10 stream ready", in_ready, 1'b1);
      @(negedge clk);
      chk_bit("R10 busy slot", in_ready, 1'b0);
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk_bit("R10 last valid", out_valid, 1'b1);
    chk_blk("R10 last data", zs[5]);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

endmodule